// File: doc/BRIEF.md
# Hex Record Command Decoder

This block sits behind a serial receiver. It takes one byte at a time and parses records written as ASCII hexadecimal text. A record starts with a colon. The colon is followed by a byte count, a 16-bit address, a record type, up to 16 payload bytes and a checksum. The block keeps the payload in a small buffer and adds up every decoded byte. It acts only after the last checksum digit has arrived and the sum is zero. Nothing reaches the flash side before that point.

Once a record is valid, the block maps its type, and for some types its subfunction, onto one or more commands toward a flash controller. The commands are: program a byte, clear the boot status byte, set a lock bit, set the clock-mode bit, erase the whole array, read a configuration byte, and start a memory dump. When the commands finish, the block sends a short reply on its output byte stream. Most replies are one status character. An identification or configuration read returns two hex digits followed by the success character. Producing the dump output itself is the job of the flash side.

The controller has six states:
- `S_IDLE` waits for a colon.
- `S_HI` takes the high digit of a byte and goes to `S_LO`. A non-hex character sends it back to `S_IDLE`.
- `S_LO` takes the low digit. It goes back to `S_HI` for the next byte. After a good checksum it goes to `S_EXEC`. After an oversize count or a bad checksum it goes to `S_REPLY`. A non-hex character sends it to `S_IDLE`.
- `S_EXEC` decodes the record. It goes to `S_CMD` when a flash command is needed and to `S_REPLY` otherwise.
- `S_CMD` holds a command until `cmd_done`. It stays there while a data record still has bytes left to program, then goes to `S_REPLY`.
- `S_REPLY` goes back to `S_IDLE` once the last reply character has been accepted.

Top module: `hex_record_decoder`

## Requirements
- R1: Outside a record, only the colon (3Ah) has any effect. Every other byte is consumed without a reply or a command.
- R2: If the count byte is above MAX_DATA (16), the block sends 'X' (58h) straight after the count byte. It then drops the record and the rest of its text, and issues no command.
- R3: A non-hex character inside a record aborts the record silently, and the block waits for a colon again. Hex digits are accepted in upper or lower case.
- R4: A record is valid only when the 8-bit sum of all decoded bytes, from the count up to and including the checksum, is zero. Otherwise the block replies 'X' and issues no command.
- R5: No command is presented before the final checksum digit has arrived. Each command is held on the port until `cmd_done`. The `cmd_op` codes are: 0 program byte, 1 clear status byte, 2 set lock bit, 3 set clock-mode bit, 4 full erase, 5 read configuration, 6 dump.
- R6: A type 00 record is refused with 'R' (52h), and nothing is programmed, unless a type 02 record has been accepted since reset.
- R7: A type 00 record with count n programs its bytes in order, at address, address+1, and so on up to address+n-1, using op 0. When all of them succeed the block replies '.' (2Eh). A count of 0 gives '.' with no command.
- R8: If a program command returns `cmd_fail`, the block programs no further bytes from that record and replies 'R'.
- R9: Type 01 and type 02 records are answered with '.' and issue no command.
- R10: Type 03 uses payload byte 0 as the subfunction:
  - 04 gives op 1.
  - 05 with selector 00, 01 or 02 (payload byte 1) gives op 2, with `cmd_data` equal to the selector.
  - 06 with selector 02 and data 80h gives op 3.
  - 07 gives op 4.
  - The reply is '.', or 'R' on `cmd_fail`. Any other subfunction or selector gives '?' (3Fh).
- R11: A type 04 record with count 5 gives op 6. The start address (payload bytes 0–1) goes on `cmd_addr`, the end address (bytes 2–3) on `cmd_addr_end`, and the mode byte (byte 4) on `cmd_data`. The reply is '.'. While `dump_lock` is high the block instead replies 'R' and issues no command.
- R12: A type 05 record uses payload bytes 0–1 as a key:
  - 0000 replies "15." and 0001 replies "C2.", with no command.
  - 0003, 0700 and 0701 give op 5 with `cmd_data` 0, 1 and 2. The reply is `cmd_rdata` as two upper-case hex digits, high digit first, then '.'.
- R13: Any other record type answers '?'. So does a known type whose count is too small for its fields (type 04 with a count other than 5), or whose key is unknown.
- R14: `in_ready` is low from the end of a record until its reply has been fully accepted. While `out_valid` is high and `out_ready` is low, `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming character valid |
| in_data | input | 8 | Incoming ASCII character |
| in_ready | output | 1 | Decoder can take a character |
| out_valid | output | 1 | Reply character valid |
| out_data | output | 8 | Reply ASCII character |
| out_ready | input | 1 | Receiver takes the reply character |
| cmd_valid | output | 1 | Flash command presented |
| cmd_op | output | 3 | Flash command code (see R5) |
| cmd_addr | output | 16 | Byte address or dump start address |
| cmd_addr_end | output | 16 | Dump end address |
| cmd_data | output | 8 | Program data, lock selector, read selector or dump mode |
| cmd_done | input | 1 | One-cycle completion of the presented command |
| cmd_fail | input | 1 | Completed command failed (valid with cmd_done) |
| cmd_rdata | input | 8 | Read result (valid with cmd_done) |
| dump_lock | input | 1 | Verify lock is set; dumps are refused |

## Verification
Suppose the controller ends up in the wrong state, or the byte index drifts. The very next record then gets the wrong character back, an 'X' for a good record or no reply at all. It is seen before the line's CR/LF is accepted, because `in_ready` stays low until the reply drains. A wrong payload index or address increment shows at the command port as soon as the first program command is presented. A stale validity flag, such as the frequency flag or a missed lock input, flips a '.' into an 'R', or lets a refused command through, within the same record.

// File: rtl/hexrec_pkg.sv
`timescale 1ns/1ps
package hexrec_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HI,
        S_LO,
        S_EXEC,
        S_CMD,
        S_REPLY
    } dec_state_e;

    typedef enum logic [2:0] {
        OP_PROG    = 3'd0,
        OP_STATUS0 = 3'd1,
        OP_LOCK    = 3'd2,
        OP_CLKMODE = 3'd3,
        OP_ERASE   = 3'd4,
        OP_READ    = 3'd5,
        OP_DUMP    = 3'd6
    } flash_op_e;

    localparam logic [7:0] CH_COLON = 8'h3A;
    localparam logic [7:0] CH_OK    = 8'h2E;
    localparam logic [7:0] CH_SUM   = 8'h58;
    localparam logic [7:0] CH_FAIL  = 8'h52;
    localparam logic [7:0] CH_UNSUP = 8'h3F;

    // upper-case ASCII digit for a nibble
    function automatic logic [7:0] hex_char(input logic [3:0] v);
        return (v < 4'd10) ? (8'h30 + {4'h0, v}) : (8'h37 + {4'h0, v});
    endfunction

endpackage

// File: rtl/hexrec_nibble.sv
`timescale 1ns/1ps
module hexrec_nibble (
    input  logic [7:0] ch,
    output logic       is_hex,
    output logic [3:0] val
);
    always_comb begin
        is_hex = 1'b1;
        val    = 4'h0;
        if (ch >= 8'h30 && ch <= 8'h39)      val = 4'(ch - 8'h30);
        else if (ch >= 8'h41 && ch <= 8'h46) val = 4'(ch - 8'h37);
        else if (ch >= 8'h61 && ch <= 8'h66) val = 4'(ch - 8'h57);
        else                                 is_hex = 1'b0;
    end
endmodule

// File: rtl/hexrec_payload.sv
`timescale 1ns/1ps
module hexrec_payload #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_idx,
    input  logic [7:0]             wr_data,
    output logic [DEPTH-1:0][7:0]  bytes_o
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_out
        assign bytes_o[g] = mem[g];
    end
endmodule

// File: rtl/hexrec_reply.sv
`timescale 1ns/1ps
module hexrec_reply (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [1:0]      len,
    input  logic [2:0][7:0] chars,
    input  logic            out_ready,
    output logic            out_valid,
    output logic [7:0]      out_data,
    output logic            busy
);
    logic [2:0][7:0] q;
    logic [1:0]      n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
            n <= 2'd0;
        end else if (load) begin
            q <= chars;
            n <= len;
        end else if (n != 2'd0 && out_ready) begin
            q <= {8'h00, q[2], q[1]};
            n <= n - 2'd1;
        end
    end

    assign out_valid = (n != 2'd0);
    assign out_data  = q[0];
    assign busy      = (n != 2'd0);

    // R14
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/hex_record_decoder.sv
`timescale 1ns/1ps
module hex_record_decoder
    import hexrec_pkg::*;
#(
    parameter int         MAX_DATA = 16,
    parameter logic [7:0] MFR_ID   = 8'h15,
    parameter logic [7:0] DEV_ID   = 8'hC2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    input  logic        out_ready,
    output logic        cmd_valid,
    output logic [2:0]  cmd_op,
    output logic [15:0] cmd_addr,
    output logic [15:0] cmd_addr_end,
    output logic [7:0]  cmd_data,
    input  logic        cmd_done,
    input  logic        cmd_fail,
    input  logic [7:0]  cmd_rdata,
    input  logic        dump_lock
);
    localparam int IDX_W = $clog2(MAX_DATA + 6);
    localparam int BUF_D = (MAX_DATA < 5) ? 5 : MAX_DATA;
    localparam int BUF_W = $clog2(BUF_D);

    dec_state_e          state, state_n;
    logic [3:0]          nib_hi, nib_val;
    logic                is_hex, accept, hdr, chk_pos, last_byte;
    logic [IDX_W-1:0]    idx;
    logic [7:0]          count, rtype, sum, byte_in, sum_next;
    logic [15:0]         addr;
    logic                freq_ok;
    logic [BUF_W-1:0]    prog_i;
    flash_op_e           op_q;
    logic [15:0]         c_addr_q, c_end_q;
    logic [7:0]          c_data_q;
    logic [BUF_D-1:0][7:0] pb;
    logic                buf_we;
    logic                rl_load, reply_busy;
    logic [1:0]          rl_len;
    logic [2:0][7:0]     rl_chars;

    // decisions made in S_EXEC
    logic                go_cmd, go_freq;
    flash_op_e           go_op;
    logic [15:0]         go_addr, go_end;
    logic [7:0]          go_data;
    logic [1:0]          go_len;
    logic [2:0][7:0]     go_chars;

    hexrec_nibble u_nib (.ch(in_data), .is_hex(is_hex), .val(nib_val));

    assign in_ready  = (state == S_IDLE) || (state == S_HI) || (state == S_LO);
    assign accept    = in_valid && in_ready;
    assign byte_in   = {nib_hi, nib_val};
    assign sum_next  = sum + byte_in;
    assign hdr       = (idx < IDX_W'(4));
    assign chk_pos   = (9'(idx) == (9'(count) + 9'd4));
    assign last_byte = ((8'(prog_i) + 8'd1) == count);
    assign buf_we    = (state == S_LO) && accept && is_hex && !hdr && !chk_pos;

    hexrec_payload #(.DEPTH(BUF_D)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_we),
        .wr_idx  (BUF_W'(idx - IDX_W'(4))),
        .wr_data (byte_in),
        .bytes_o (pb)
    );

    hexrec_reply u_reply (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rl_load),
        .len       (rl_len),
        .chars     (rl_chars),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .busy      (reply_busy)
    );

    // record decode, meaningful in S_EXEC
    always_comb begin
        go_cmd   = 1'b0;
        go_freq  = 1'b0;
        go_op    = OP_PROG;
        go_addr  = addr;
        go_end   = addr;
        go_data  = pb[0];
        go_len   = 2'd1;
        go_chars = {8'h00, 8'h00, CH_OK};
        unique case (rtype)
            8'h00: begin
                if (!freq_ok)            go_chars[0] = CH_FAIL;
                else if (count != 8'd0)  go_cmd = 1'b1;
            end
            8'h01: ;
            8'h02: go_freq = 1'b1;
            8'h03: begin
                if (count == 8'd0) go_chars[0] = CH_UNSUP;
                else begin
                    case (pb[0])
                        8'h04: begin go_cmd = 1'b1; go_op = OP_STATUS0; end
                        8'h05: begin
                            if (count >= 8'd2 && pb[1] <= 8'h02) begin
                                go_cmd = 1'b1; go_op = OP_LOCK; go_data = pb[1];
                            end else go_chars[0] = CH_UNSUP;
                        end
                        8'h06: begin
                            if (count >= 8'd3 && pb[1] == 8'h02 && pb[2] == 8'h80) begin
                                go_cmd = 1'b1; go_op = OP_CLKMODE; go_data = pb[2];
                            end else go_chars[0] = CH_UNSUP;
                        end
                        8'h07: begin go_cmd = 1'b1; go_op = OP_ERASE; end
                        default: go_chars[0] = CH_UNSUP;
                    endcase
                end
            end
            8'h04: begin
                if (count != 8'd5)  go_chars[0] = CH_UNSUP;
                else if (dump_lock) go_chars[0] = CH_FAIL;
                else begin
                    go_cmd  = 1'b1;
                    go_op   = OP_DUMP;
                    go_addr = {pb[0], pb[1]};
                    go_end  = {pb[2], pb[3]};
                    go_data = pb[4];
                end
            end
            8'h05: begin
                if (count < 8'd2) go_chars[0] = CH_UNSUP;
                else begin
                    case ({pb[0], pb[1]})
                        16'h0000: begin
                            go_len   = 2'd3;
                            go_chars = {CH_OK, hex_char(MFR_ID[3:0]), hex_char(MFR_ID[7:4])};
                        end
                        16'h0001: begin
                            go_len   = 2'd3;
                            go_chars = {CH_OK, hex_char(DEV_ID[3:0]), hex_char(DEV_ID[7:4])};
                        end
                        16'h0003: begin go_cmd = 1'b1; go_op = OP_READ; go_data = 8'd0; end
                        16'h0700: begin go_cmd = 1'b1; go_op = OP_READ; go_data = 8'd1; end
                        16'h0701: begin go_cmd = 1'b1; go_op = OP_READ; go_data = 8'd2; end
                        default:  go_chars[0] = CH_UNSUP;
                    endcase
                end
            end
            default: go_chars[0] = CH_UNSUP;
        endcase
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: if (accept && in_data == CH_COLON) state_n = S_HI;
            S_HI:   if (accept) state_n = is_hex ? S_LO : S_IDLE;
            S_LO: begin
                if (accept) begin
                    if (!is_hex)                                         state_n = S_IDLE;
                    else if (idx == IDX_W'(0) && byte_in > 8'(MAX_DATA)) state_n = S_REPLY;
                    else if (!hdr && chk_pos)  state_n = (sum_next == 8'h00) ? S_EXEC : S_REPLY;
                    else                                                 state_n = S_HI;
                end
            end
            S_EXEC: state_n = go_cmd ? S_CMD : S_REPLY;
            S_CMD: begin
                if (cmd_done && !(op_q == OP_PROG && !cmd_fail && !last_byte))
                    state_n = S_REPLY;
            end
            S_REPLY: if (!rl_load && !reply_busy) state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nib_hi   <= 4'h0;
            idx      <= '0;
            count    <= 8'h00;
            rtype    <= 8'h00;
            sum      <= 8'h00;
            addr     <= 16'h0000;
            freq_ok  <= 1'b0;
            prog_i   <= '0;
            op_q     <= OP_PROG;
            c_addr_q <= 16'h0000;
            c_end_q  <= 16'h0000;
            c_data_q <= 8'h00;
            rl_load  <= 1'b0;
            rl_len   <= 2'd0;
            rl_chars <= '0;
        end else begin
            rl_load <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    idx <= '0;
                    sum <= 8'h00;
                end
                S_HI: if (accept && is_hex) nib_hi <= nib_val;
                S_LO: begin
                    if (accept && is_hex) begin
                        idx <= idx + IDX_W'(1);
                        sum <= sum_next;
                        case (idx)
                            IDX_W'(0): count       <= byte_in;
                            IDX_W'(1): addr[15:8]  <= byte_in;
                            IDX_W'(2): addr[7:0]   <= byte_in;
                            IDX_W'(3): rtype       <= byte_in;
                            default: ;
                        endcase
                        if ((idx == IDX_W'(0) && byte_in > 8'(MAX_DATA)) ||
                            (!hdr && chk_pos && sum_next != 8'h00)) begin
                            rl_load  <= 1'b1;
                            rl_len   <= 2'd1;
                            rl_chars <= {8'h00, 8'h00, CH_SUM};
                        end
                    end
                end
                S_EXEC: begin
                    if (go_freq) freq_ok <= 1'b1;
                    if (go_cmd) begin
                        op_q     <= go_op;
                        c_addr_q <= go_addr;
                        c_end_q  <= go_end;
                        c_data_q <= go_data;
                        prog_i   <= '0;
                    end else begin
                        rl_load  <= 1'b1;
                        rl_len   <= go_len;
                        rl_chars <= go_chars;
                    end
                end
                S_CMD: begin
                    if (cmd_done) begin
                        if (op_q == OP_PROG && !cmd_fail && !last_byte) begin
                            prog_i   <= prog_i + BUF_W'(1);
                            c_addr_q <= c_addr_q + 16'd1;
                            c_data_q <= pb[BUF_W'(prog_i + BUF_W'(1))];
                        end else begin
                            rl_load <= 1'b1;
                            if (cmd_fail) begin
                                rl_len   <= 2'd1;
                                rl_chars <= {8'h00, 8'h00, CH_FAIL};
                            end else if (op_q == OP_READ) begin
                                rl_len   <= 2'd3;
                                rl_chars <= {CH_OK, hex_char(cmd_rdata[3:0]), hex_char(cmd_rdata[7:4])};
                            end else begin
                                rl_len   <= 2'd1;
                                rl_chars <= {8'h00, 8'h00, CH_OK};
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign cmd_valid    = (state == S_CMD);
    assign cmd_op       = op_q;
    assign cmd_addr     = c_addr_q;
    assign cmd_addr_end = c_end_q;
    assign cmd_data     = c_data_q;

    // R14
    reply_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    // R5
    cmd_after_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !in_ready);
    // R6
    prog_needs_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == 3'd0 |-> freq_ok);
    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HI && !hdr) |-> count <= 8'(MAX_DATA));
    // R11
    dump_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) && cmd_op == 3'd6 |-> !dump_lock);
    // R5
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_data));
endmodule

// File: tb/tb_hex_record_decoder.sv
`timescale 1ns/1ps
module tb_hex_record_decoder;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready, out_valid, out_ready = 1'b1;
    logic [7:0]  out_data;
    logic        cmd_valid, cmd_done, cmd_fail;
    logic [2:0]  cmd_op;
    logic [15:0] cmd_addr, cmd_addr_end;
    logic [7:0]  cmd_data, cmd_rdata;
    logic        dump_lock;

    hex_record_decoder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_addr_end(cmd_addr_end),
        .cmd_data(cmd_data), .cmd_done(cmd_done), .cmd_fail(cmd_fail), .cmd_rdata(cmd_rdata),
        .dump_lock(dump_lock)
    );

    int checks = 0, errors = 0;
    bit summary_done = 0;

    // flash model
    logic [7:0]  m_status;
    logic [2:0]  m_lock;
    logic        m_clk;
    int          dly = 0, ops_n = 0, prog_n = 0, dump_n = 0;
    logic [15:0] prog_a [256];
    logic [7:0]  prog_d [256];
    logic [15:0] dump_s, dump_e;
    logic [7:0]  dump_m;
    assign dump_lock = m_lock[1];

    always @(posedge clk) begin
        if (!rst_n) begin
            cmd_done <= 1'b0; cmd_fail <= 1'b0; cmd_rdata <= 8'h00; dly <= 0;
            m_status <= 8'hFF; m_lock <= 3'b000; m_clk <= 1'b0;
        end else begin
            cmd_done <= 1'b0;
            if (cmd_valid && !cmd_done) begin
                if (dly < 2) dly <= dly + 1;
                else begin
                    dly <= 0; cmd_done <= 1'b1; cmd_fail <= 1'b0; ops_n <= ops_n + 1;
                    case (cmd_op)
                        3'd0: begin
                            prog_a[prog_n] <= cmd_addr; prog_d[prog_n] <= cmd_data;
                            prog_n <= prog_n + 1;
                            cmd_fail <= (cmd_addr[15:8] == 8'hFF);
                        end
                        3'd1: m_status <= 8'h00;
                        3'd2: m_lock[cmd_data[1:0]] <= 1'b1;
                        3'd3: m_clk <= 1'b1;
                        3'd4: begin m_status <= 8'hFF; m_lock <= 3'b000; m_clk <= 1'b0; end
                        3'd5: cmd_rdata <= (cmd_data == 8'd0) ? {m_clk, 7'd0} :
                                           (cmd_data == 8'd1) ? {5'd0, m_lock} : m_status;
                        3'd6: begin dump_n <= dump_n + 1; dump_s <= cmd_addr; dump_e <= cmd_addr_end; dump_m <= cmd_data; end
                        default: ;
                    endcase
                end
            end
        end
    end

    // reply collector
    logic [7:0] rx [8192];
    int rx_n = 0;
    always @(negedge clk) if (out_valid && out_ready) begin rx[rx_n] = out_data; rx_n++; end

    logic [7:0] d [256];
    bit lc = 0;

    task automatic chk(input bit ok, input string req, input string what);
        checks++;
        if (!ok) begin errors++; $display("FAIL %s: %s", req, what); end
    endtask

    function automatic logic [7:0] hx(input logic [3:0] v);
        if (v < 4'd10) return 8'h30 + {4'h0, v};
        return (lc ? 8'h57 : 8'h37) + {4'h0, v};
    endfunction

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_data = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_hex(input logic [7:0] b);
        send_byte(hx(b[7:4])); send_byte(hx(b[3:0]));
    endtask

    task automatic send_rec(input int n, input logic [15:0] a, input logic [7:0] t, input bit bad);
        logic [7:0] s;
        s = 8'(n) + a[15:8] + a[7:0] + t;
        send_byte(8'h3A); send_hex(8'(n)); send_hex(a[15:8]); send_hex(a[7:0]); send_hex(t);
        for (int i = 0; i < n; i++) begin send_hex(d[i]); s = s + d[i]; end
        s = 8'h00 - s;
        if (bad) s = s + 8'h01;
        send_hex(s); send_byte(8'h0D); send_byte(8'h0A);
    endtask

    task automatic expect_rx(input int mark, input string exp, input string req);
        string act;
        act = "";
        for (int i = mark; i < rx_n; i++) act = {act, $sformatf("%c", rx[i])};
        chk(act == exp, req, $sformatf("reply \"%s\" expected \"%s\"", act, exp));
    endtask

    task automatic rec(input int n, input logic [15:0] a, input logic [7:0] t, input bit bad,
                       input string exp, input int exp_ops, input string req);
        int mark, o;
        mark = rx_n; o = ops_n;
        send_rec(n, a, t, bad);
        repeat (2) @(negedge clk);
        expect_rx(mark, exp, req);
        chk(ops_n - o == exp_ops, req, $sformatf("commands %0d expected %0d", ops_n - o, exp_ops));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        if (!summary_done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int mark, pn, o;
        repeat (4) @(negedge clk);
        // R14 reset state
        chk(!out_valid && !cmd_valid && in_ready, "R14",
            $sformatf("reset out_valid=%0b cmd_valid=%0b in_ready=%0b expected 0 0 1", out_valid, cmd_valid, in_ready));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 text outside a record
        mark = rx_n; o = ops_n;
        send_byte(8'h41); send_byte(8'h30); send_byte(8'h0D); send_byte(8'h0A); send_byte(8'h5A);
        repeat (4) @(negedge clk);
        expect_rx(mark, "", "R1");
        chk(ops_n == o, "R1", $sformatf("commands %0d expected 0", ops_n - o));

        // R6 data before frequency setup
        d[0] = 8'h11; d[1] = 8'h22;
        rec(2, 16'h0100, 8'h00, 0, "R", 0, "R6");
        // R9 end-of-file and frequency
        rec(0, 16'h0000, 8'h01, 0, ".", 0, "R9");
        d[0] = 8'd12;
        rec(1, 16'h0000, 8'h02, 0, ".", 0, "R9");

        // R7 sweep counts 0..16
        for (int n = 0; n <= 16; n++) begin
            for (int i = 0; i < n; i++) d[i] = 8'(n * 7 + i * 13 + 1);
            pn = prog_n;
            rec(n, 16'(16'h1000 + n * 32), 8'h00, 0, ".", n, "R7");
            for (int i = 0; i < n; i++)
                chk(prog_a[pn + i] == 16'(16'h1000 + n * 32 + i) && prog_d[pn + i] == d[i], "R7",
                    $sformatf("byte %0d addr %h data %h expected %h %h", i, prog_a[pn + i], prog_d[pn + i],
                              16'(16'h1000 + n * 32 + i), d[i]));
        end

        // R8 failure at third byte stops programming
        for (int i = 0; i < 4; i++) d[i] = 8'(8'hA0 + i);
        pn = prog_n;
        rec(4, 16'hFEFE, 8'h00, 0, "R", 3, "R8");
        chk(prog_a[pn + 2] == 16'hFF00, "R8", $sformatf("last addr %h expected FF00", prog_a[pn + 2]));

        // R4 bad checksum on every known type
        for (int t = 0; t <= 5; t++) rec(0, 16'h0000, 8'(t), 1, "X", 0, "R4");
        d[0] = 8'h04; d[1] = 8'h00;
        rec(2, 16'h0000, 8'h03, 1, "X", 0, "R4");

        // R2 oversize counts
        for (int i = 0; i < 255; i++) d[i] = 8'(i);
        rec(17, 16'h2000, 8'h00, 0, "X", 0, "R2");
        rec(40, 16'h2000, 8'h00, 0, "X", 0, "R2");
        rec(255, 16'h2000, 8'h00, 0, "X", 0, "R2");

        // R3 non-hex aborts, lower case accepted
        mark = rx_n;
        send_byte(8'h3A); send_byte(8'h30); send_byte(8'h31); send_byte(8'h47);
        send_byte(8'h30); send_byte(8'h30);
        repeat (4) @(negedge clk);
        expect_rx(mark, "", "R3");
        rec(0, 16'h0000, 8'h01, 0, ".", 0, "R3");
        lc = 1; d[0] = 8'h00; d[1] = 8'h01;
        rec(2, 16'hABCD, 8'h05, 0, "C2.", 0, "R3");
        lc = 0;

        // R5 nothing before the last checksum digit
        mark = rx_n; o = ops_n;
        send_byte(8'h3A);
        send_hex(8'h02); send_hex(8'h00); send_hex(8'h00); send_hex(8'h03); send_hex(8'h04); send_hex(8'h00);
        send_byte(8'h46);
        repeat (20) @(negedge clk);
        chk(!cmd_valid && ops_n == o, "R5", $sformatf("cmd_valid=%0b commands %0d expected 0", cmd_valid, ops_n - o));
        send_byte(8'h37); send_byte(8'h0D); send_byte(8'h0A);
        repeat (2) @(negedge clk);
        expect_rx(mark, ".", "R5");
        chk(m_status == 8'h00, "R10", $sformatf("status %h expected 00", m_status));

        // R11 dump allowed
        d[0] = 8'h40; d[1] = 8'h00; d[2] = 8'h4F; d[3] = 8'hFF; d[4] = 8'h01;
        o = dump_n;
        rec(5, 16'h0000, 8'h04, 0, ".", 1, "R11");
        chk(dump_n == o + 1 && dump_s == 16'h4000 && dump_e == 16'h4FFF && dump_m == 8'h01, "R11",
            $sformatf("dump %h-%h mode %h expected 4000-4FFF 01", dump_s, dump_e, dump_m));
        rec(4, 16'h0000, 8'h04, 0, "?", 0, "R13");

        // R10 lock bits, clock mode, bad selectors
        d[0] = 8'h05; d[1] = 8'h00; rec(2, 16'h0000, 8'h03, 0, ".", 1, "R10");
        d[1] = 8'h02;               rec(2, 16'h0000, 8'h03, 0, ".", 1, "R10");
        d[1] = 8'h03;               rec(2, 16'h0000, 8'h03, 0, "?", 0, "R10");
        chk(m_lock == 3'b101, "R10", $sformatf("lock %b expected 101", m_lock));
        // R12 reads through the flash port
        d[0] = 8'h07; d[1] = 8'h00; rec(2, 16'h0000, 8'h05, 0, "05.", 1, "R12");
        d[1] = 8'h01;               rec(2, 16'h0000, 8'h05, 0, "00.", 1, "R12");
        d[0] = 8'h06; d[1] = 8'h02; d[2] = 8'h81; rec(3, 16'h0000, 8'h03, 0, "?", 0, "R10");
        d[2] = 8'h80;               rec(3, 16'h0000, 8'h03, 0, ".", 1, "R10");
        d[0] = 8'h00; d[1] = 8'h03; rec(2, 16'h0000, 8'h05, 0, "80.", 1, "R12");
        d[0] = 8'h00; d[1] = 8'h00; rec(2, 16'h0000, 8'h05, 0, "15.", 0, "R12");
        d[1] = 8'h02;               rec(2, 16'h0000, 8'h05, 0, "?", 0, "R13");
        d[0] = 8'h08;               rec(1, 16'h0000, 8'h03, 0, "?", 0, "R10");

        // R11 dump refused with verify lock
        d[0] = 8'h05; d[1] = 8'h01; rec(2, 16'h0000, 8'h03, 0, ".", 1, "R10");
        d[0] = 8'h07; d[1] = 8'h00; rec(2, 16'h0000, 8'h05, 0, "07.", 1, "R12");
        d[0] = 8'h00; d[1] = 8'h00; d[2] = 8'h0F; d[3] = 8'hFF; d[4] = 8'h00;
        rec(5, 16'h0000, 8'h04, 0, "R", 0, "R11");

        // R10 full erase
        d[0] = 8'h07; rec(1, 16'h0000, 8'h03, 0, ".", 1, "R10");
        d[0] = 8'h07; d[1] = 8'h01; rec(2, 16'h0000, 8'h05, 0, "FF.", 1, "R12");
        d[1] = 8'h00;               rec(2, 16'h0000, 8'h05, 0, "00.", 1, "R12");

        // R13 every other record type
        for (int t = 6; t <= 255; t++) rec(0, 16'h0000, 8'(t), 0, "?", 0, "R13");

        // R14 reply held while the receiver stalls
        out_ready = 1'b0;
        d[0] = 8'h00; d[1] = 8'h00;
        fork
            rec(2, 16'h0000, 8'h05, 0, "15.", 0, "R14");
            begin : stall
                logic [7:0] first;
                wait (out_valid == 1'b1);
                @(negedge clk);
                first = out_data;
                for (int k = 0; k < 6; k++) begin
                    @(negedge clk);
                    chk(out_valid && out_data == first && !in_ready, "R14",
                        $sformatf("valid=%0b data %h in_ready=%0b expected 1 %h 0", out_valid, out_data, in_ready, first));
                end
                chk(first == 8'h31, "R14", $sformatf("first char %h expected 31", first));
                out_ready = 1'b1;
            end
        join

        summary_done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule